// File: doc/BRIEF.md
# Thermal Channel Sample Scheduler with Averaging

This block controls acquisition for one channel of a thermal sensor front end. It decides when a conversion is needed, requests converter results through a request/acknowledge handshake, and averages a power-of-two number of valid 12-bit results. It then publishes the average to a data output and sets sticky status flags. A measurement can be started once, as a single shot, or repeatedly by an interval timer. The timer counts in units of `PRESCALE` clock cycles, which defaults to 65536.

Software-style configuration arrives through a write-only word port that has a 3-bit word select:

| Select | Word | Fields |
|---|---|---|
| 0 | control | bit 0 global enable, bit 1 channel enable |
| 1 | mode | bit 0 single-shot request (set-only), bit 1 periodic enable |
| 2 | interval | bits 31:16 period in `PRESCALE` units |
| 3 | filter | bits 1:0 averaging code |
| 4 | status | bit 16 clears ready, bit 17 clears overwrite (write-1-to-clear) |

The sequencer has three states:
- `S_IDLE`: accumulator cleared, no request.
- `S_CONV`: `conv_req` held high while results are collected.
- `S_PUB`: the average is published.

It has four transitions:
- start: `S_IDLE` to `S_CONV`, taken when both enables are set and either a single-shot request is pending or the timer fires.
- abort: `S_CONV` to `S_IDLE`, taken when an enable is cleared.
- finish: `S_CONV` to `S_PUB`, taken on the last valid result.
- return: `S_PUB` to `S_IDLE`.

Top module: `tsa_sampler`

## Requirements
- R1: After reset `data_o` is 0, `rdy_o` and `ovw_o` are 0, `mode_o` is 0 and `conv_req` is low.
- R2: No conversion is requested unless both the global enable (control bit 0) and the channel enable (control bit 1) are set. A pending single-shot request stays pending until both are set.
- R3: Writing 1 to mode bit 0 starts exactly one measurement. The bit reads back through `mode_o[0]` and clears only when that measurement publishes. Writing 0 to it has no effect.
- R4: With mode bit 1 set, a measurement starts every `interval*PRESCALE` cycles, so consecutive rising edges of `conv_req` are that far apart. An interval of 0 acts as 1. A trigger that arrives while a measurement is running is dropped.
- R5: Filter code 0, 1, 2 or 3 averages 1, 2, 4 or 8 valid results. The published value is floor(sum / count).
- R6: Results equal to 0 or 4095 are invalid. They are not accumulated, they do not count toward the sample count, and the request stays high for another result.
- R7: Publishing a result updates `data_o` and sets `rdy_o` (status bit 16) in the same cycle.
- R8: Publishing while `rdy_o` is still set and not being cleared in that cycle sets `ovw_o` (status bit 17).
- R9: A status write clears each flag whose bit is 1 and leaves each flag whose bit is 0 unchanged. Both flags are sticky otherwise.
- R10: Clearing either enable during a measurement drops `conv_req` by the following cycle and discards the partial sum without publishing. Re-enabling starts a fresh measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| conv_req | output | 1 | Converter request, held while results are wanted |
| conv_ack | input | 1 | One-cycle strobe: `conv_data` is valid |
| conv_data | input | 12 | Converter result |
| data_o | output | 12 | Last published average |
| rdy_o | output | 1 | Data-ready flag |
| ovw_o | output | 1 | Data-overwrite flag |
| mode_o | output | 2 | Current mode bits (single pending, periodic) |

## Verification
If the accumulator or sample counter goes wrong, `data_o` is off by a predictable amount, or the converter model has supplied a different number of results, when `rdy_o` rises. Both are visible within one measurement. If the sequencer is left in the wrong state, `conv_req` stays high after an enable drops, or a single-shot bit never clears, and this shows within a few cycles. A wrong interval counter shifts the spacing of `conv_req` rising edges by whole prescaler units, so two consecutive periodic starts expose it.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CONV = 2'd1,
        S_PUB  = 2'd2
    } tsa_state_e;

    localparam logic [2:0] SEL_CTL  = 3'd0;
    localparam logic [2:0] SEL_MODE = 3'd1;
    localparam logic [2:0] SEL_ITV  = 3'd2;
    localparam logic [2:0] SEL_FILT = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;
endpackage

// File: rtl/tsa_interval_timer.sv
module tsa_interval_timer #(
    parameter int PRESCALE = 65536,
    parameter int ITW      = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [ITW-1:0] period,
    output logic           fire
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0]  pre_q;
    logic [ITW-1:0] unit_q;
    logic [ITW-1:0] last_unit;
    logic           pre_wrap;

    assign last_unit = (period == '0) ? '0 : period - 1'b1;
    assign pre_wrap  = (pre_q == PRE_LAST);
    assign fire      = run && pre_wrap && (unit_q >= last_unit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (!run) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (pre_wrap) begin
            pre_q  <= '0;
            unit_q <= (unit_q >= last_unit) ? '0 : unit_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/tsa_averager.sv
module tsa_averager #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] sample,
    input  logic [1:0]    code,
    output logic          last,
    output logic [DW-1:0] avg
);
    localparam int AW = DW + 3;

    logic [AW-1:0] acc_q;
    logic [2:0]    cnt_q;
    logic [2:0]    lim;

    assign lim  = 3'((4'd1 << code) - 4'd1);
    assign last = (cnt_q == lim);
    assign avg  = DW'(acc_q >> code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (add) begin
            acc_q <= acc_q + AW'(sample);
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tsa_sampler.sv
module tsa_sampler #(
    parameter int DW       = 12,
    parameter int PRESCALE = 65536,
    parameter int ITW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic          conv_req,
    input  logic          conv_ack,
    input  logic [DW-1:0] conv_data,
    output logic [DW-1:0] data_o,
    output logic          rdy_o,
    output logic          ovw_o,
    output logic [1:0]    mode_o
);
    import tsa_pkg::*;

    localparam logic [DW-1:0] CODE_MAX = '1;

    tsa_state_e     state_q, state_d;
    logic [1:0]     ctl_q;
    logic [1:0]     mode_q;
    logic [ITW-1:0] itv_q;
    logic [1:0]     filt_q, filt_run_q;
    logic           en_ok, fire, start, valid, take, last, pub;
    logic           clr_rdy, clr_ovw;
    logic [DW-1:0]  avg;
    logic           unused_w;

    assign unused_w = ^cfg_wdata[15:2];

    assign en_ok   = ctl_q[0] & ctl_q[1];
    assign start   = en_ok & (mode_q[0] | fire);
    assign valid   = (conv_data != '0) && (conv_data != CODE_MAX);
    assign take    = (state_q == S_CONV) && en_ok && conv_ack && valid;
    assign pub     = (state_q == S_PUB);
    assign clr_rdy = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[16];
    assign clr_ovw = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[17];

    tsa_interval_timer #(.PRESCALE(PRESCALE), .ITW(ITW)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en_ok & mode_q[1]),
        .period (itv_q),
        .fire   (fire)
    );

    tsa_averager #(.DW(DW)) i_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == S_IDLE),
        .add    (take),
        .sample (conv_data),
        .code   (filt_run_q),
        .last   (last),
        .avg    (avg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, abort, finish, return
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_CONV;
            S_CONV: begin
                if (!en_ok)          state_d = S_IDLE;
                else if (take && last) state_d = S_PUB;
            end
            S_PUB:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign conv_req = (state_q == S_CONV);

    // outputs and configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            mode_q     <= '0;
            itv_q      <= '0;
            filt_q     <= '0;
            filt_run_q <= '0;
            data_o     <= '0;
            rdy_o      <= 1'b0;
            ovw_o      <= 1'b0;
        end else begin
            if (state_q == S_IDLE) filt_run_q <= filt_q;
            if (cfg_we) begin
                unique case (cfg_sel)
                    SEL_CTL:  ctl_q <= cfg_wdata[1:0];
                    SEL_MODE: begin
                        mode_q[1] <= cfg_wdata[1];
                        if (cfg_wdata[0]) mode_q[0] <= 1'b1;
                    end
                    SEL_ITV:  itv_q  <= cfg_wdata[31:16];
                    SEL_FILT: filt_q <= cfg_wdata[1:0];
                    default: ;
                endcase
            end
            if (pub) begin
                data_o    <= avg;
                rdy_o     <= 1'b1;
                ovw_o     <= ovw_o | (rdy_o & ~clr_rdy);
                mode_q[0] <= 1'b0;
            end else begin
                if (clr_rdy) rdy_o <= 1'b0;
                if (clr_ovw) ovw_o <= 1'b0;
            end
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/tsa_sampler_chk.sv
module tsa_sampler_chk
    import tsa_pkg::*;
#(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input tsa_state_e    state,
    input logic          en_ok,
    input logic          conv_req,
    input logic          conv_ack,
    input logic [DW-1:0] conv_data,
    input logic          rdy_o,
    input logic          ovw_o,
    input logic [1:0]    mode_o,
    input logic          clr_rdy,
    input logic          clr_ovw
);
    // R2: nothing is requested while idle and not enabled
    a_r2_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ok && state == S_IDLE) |=> !conv_req);

    // R10: a dropped enable ends the request by the next cycle
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ok |=> !conv_req);

    // R6: an invalid code keeps the request alive
    a_r6_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CONV && en_ok && conv_ack &&
         (conv_data == '0 || conv_data == '1)) |=> conv_req);

    // R7: a publish raises the ready flag
    a_r7_ready_on_publish: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUB) |=> rdy_o);

    // R8: publishing over unacknowledged data flags an overwrite
    a_r8_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUB && rdy_o && !clr_rdy) |=> ovw_o);

    // R9: the overwrite flag is sticky until cleared
    a_r9_ovw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovw_o && !clr_ovw) |=> ovw_o);

    // R3: the single-shot bit falls only after a publish
    a_r3_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_o[0]) |-> $past(state == S_PUB));
endmodule

bind tsa_sampler tsa_sampler_chk #(.DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .en_ok     (en_ok),
    .conv_req  (conv_req),
    .conv_ack  (conv_ack),
    .conv_data (conv_data),
    .rdy_o     (rdy_o),
    .ovw_o     (ovw_o),
    .mode_o    (mode_o),
    .clr_rdy   (clr_rdy),
    .clr_ovw   (clr_ovw)
);

// File: tb/test_tsa_sampler.sv
`timescale 1ns/1ps
module test_tsa_sampler;
    localparam int PRE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        conv_req;
    logic        conv_ack = 1'b0;
    logic [11:0] conv_data = '0;
    logic [11:0] data_o;
    logic        rdy_o, ovw_o;
    logic [1:0]  mode_o;

    int total = 0;
    int bad = 0;
    int ptr = 0;
    int cyc = 0;
    int samp [0:15];
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tsa_sampler #(.PRESCALE(PRE)) i_tsa_sampler (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .conv_req(conv_req), .conv_ack(conv_ack),
        .conv_data(conv_data), .data_o(data_o), .rdy_o(rdy_o),
        .ovw_o(ovw_o), .mode_o(mode_o)
    );

    // converter model: answers two cycles into a held request
    initial begin
        int lat = 0;
        forever begin
            @(posedge clk);
            #1;
            conv_ack = 1'b0;
            if (conv_req) begin
                lat++;
                if (lat >= 2) begin
                    conv_ack  = 1'b1;
                    conv_data = 12'(samp[ptr % 16]);
                    ptr++;
                    lat = 0;
                end
            end else lat = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rdy();
        int k = 0;
        @(negedge clk);
        while (!rdy_o && k < 1000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_rise(output int c);
        int k = 0;
        while (conv_req && k < 500) begin @(negedge clk); k++; end
        while (!conv_req && k < 500) begin @(negedge clk); k++; end
        c = cyc;
    endtask

    task automatic single(input int code, input int exp_avg, input int exp_n, input bit clear);
        ptr = 0;
        wr(3'd3, 32'(code));
        if (clear) wr(3'd4, 32'h0003_0000);
        wr(3'd1, 32'h1);
        if (clear) begin
            wait_rdy();
        end else begin
            int k = 0;
            while (mode_o[0] && k < 1000) begin @(negedge clk); k++; end
        end
        idle(1);
        check("R5 average", int'(data_o), exp_avg);
        check("R5 sample count", ptr, exp_n);
        check("R3 single bit cleared", int'(mode_o[0]), 0);
        check("R7 ready set", int'(rdy_o), 1);
    endtask

    initial begin
        int c1, c2, sum, n;
        repeat (3) @(negedge clk);
        check("R1 data", int'(data_o), 0);
        check("R1 rdy", int'(rdy_o), 0);
        check("R1 ovw", int'(ovw_o), 0);
        check("R1 mode", int'(mode_o), 0);
        check("R1 req", int'(conv_req), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: single pending with only global enable
        for (int i = 0; i < 16; i++) samp[i] = 1000 + i;
        wr(3'd0, 32'h1);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h1);
        idle(40);
        check("R2 no conversion", ptr, 0);
        check("R2 request still pending", int'(mode_o[0]), 1);
        check("R2 no data", int'(rdy_o), 0);
        wr(3'd0, 32'h3);
        wait_rdy();
        idle(1);
        check("R2 runs once enabled", int'(data_o), 1000);

        // R5 sweep: filter codes x sample patterns
        for (int s = 0; s < 6; s++) begin
            for (int code = 0; code < 4; code++) begin
                n = 1 << code;
                sum = 0;
                for (int i = 0; i < 16; i++) samp[i] = ((s * 37 + i * 523 + code * 911) % 4094) + 1;
                for (int i = 0; i < n; i++) sum += samp[i];
                single(code, sum / n, n, 1'b1);
            end
        end

        // R6: invalid codes skipped
        samp[0] = 0; samp[1] = 100; samp[2] = 4095; samp[3] = 200; samp[4] = 4095; samp[5] = 7;
        single(1, 150, 4, 1'b1);
        check("R6 ovw untouched", int'(ovw_o), 0);

        // R8: publish over unread data
        for (int i = 0; i < 16; i++) samp[i] = 3000;
        single(0, 3000, 1, 1'b0);
        check("R8 overwrite set", int'(ovw_o), 1);

        // R9: write-1-to-clear semantics
        wr(3'd4, 32'h0);
        check("R9 zero write keeps rdy", int'(rdy_o), 1);
        check("R9 zero write keeps ovw", int'(ovw_o), 1);
        wr(3'd4, 32'h0002_0000);
        check("R9 ovw cleared", int'(ovw_o), 0);
        check("R9 rdy kept", int'(rdy_o), 1);
        wr(3'd4, 32'h0001_0000);
        check("R9 rdy cleared", int'(rdy_o), 0);
        single(0, 3000, 1, 1'b0);
        check("R8 no overwrite after ack", int'(ovw_o), 0);

        // R3: writing 0 to single bit does not start anything
        ptr = 0;
        wr(3'd1, 32'h0);
        idle(30);
        check("R3 zero write no effect", ptr, 0);

        // R10: abort mid-measurement
        wr(3'd4, 32'h0003_0000);
        for (int i = 0; i < 16; i++) samp[i] = 500 + 8 * i;
        ptr = 0;
        wr(3'd3, 32'h3);
        wr(3'd1, 32'h1);
        begin
            int k = 0;
            while (ptr < 3 && k < 200) begin @(negedge clk); k++; end
        end
        wr(3'd0, 32'h1);
        idle(1);
        check("R10 request dropped", int'(conv_req), 0);
        idle(40);
        check("R10 nothing published", int'(rdy_o), 0);
        check("R10 single still pending", int'(mode_o[0]), 1);
        ptr = 0;
        wr(3'd0, 32'h3);
        wait_rdy();
        idle(1);
        sum = 0;
        for (int i = 0; i < 8; i++) sum += 500 + 8 * i;
        check("R10 fresh restart average", int'(data_o), sum / 8);
        check("R10 fresh restart count", ptr, 8);

        // R4: periodic spacing
        wr(3'd3, 32'h0);
        wr(3'd2, 32'h0003_0000);
        wr(3'd1, 32'h2);
        wait_rise(c1);
        wait_rise(c2);
        check("R4 period 3 units", c2 - c1, 3 * PRE);
        wait_rise(c1);
        check("R4 period repeats", c1 - c2, 3 * PRE);
        wr(3'd1, 32'h0);
        idle(20);
        wr(3'd2, 32'h0);
        wr(3'd1, 32'h2);
        wait_rise(c1);
        wait_rise(c2);
        check("R4 interval zero acts as one", c2 - c1, PRE);
        wr(3'd1, 32'h0);
        idle(20);
        ptr = 0;
        idle(3 * PRE);
        check("R4 stops when cleared", ptr, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule